// File: doc/BRIEF.md
# Ripple-Through FIFO with Level-Strobe Handshake

This block is a 64-word by 4-bit first-in first-out buffer. It uses no read or write pointers. Each word sits in a cell that has its own occupancy flag. A word moves one cell toward the output end on any clock in which the next cell is empty. Words therefore pile up at the output end, and empty cells drift back toward the input end. The first cell is the input stage, 62 cells form the chain, and the last cell is the output stage.

The write side uses a level strobe `shift_in` and a status line `in_ready`. The read side uses a level strobe `shift_out` and a status line `out_ready`. Both strobes pass through a two-flop register on the system clock, and their edges are detected from the registered values.

- A rising edge of a strobe starts a transfer.
- The falling edge of the strobe completes it.
- While a strobe is held high, the word it refers to stays where it is.

The write state machine has three states:
- `WR_OPEN`: the input stage is empty and `in_ready` is high.
- `WR_HOLD`: a word has been captured and is held for as long as `shift_in` stays high.
- `WR_DRAIN`: the word has been released and is waiting to leave the input stage.

Its transitions are:
- `WR_OPEN`→`WR_HOLD` on a rising strobe, which also captures `data_in`.
- `WR_HOLD`→`WR_DRAIN` on a falling strobe.
- `WR_DRAIN`→`WR_OPEN` once the input stage is empty.

The read state machine has three states:
- `RD_EMPTY`: the output stage holds no word.
- `RD_READY`: a valid word is present and `out_ready` is high.
- `RD_HOLD`: the word is being read and `data_out` is frozen.

Its transitions are:
- `RD_EMPTY`→`RD_READY` when a word reaches the output stage.
- `RD_READY`→`RD_HOLD` on a rising `shift_out`.
- `RD_HOLD`→`RD_EMPTY` on a falling `shift_out`, which removes the word.

Top module: `ripple_fifo`

## Requirements
- R1: Words leave in the order they were written; 64 words can be held at once.
- R2: `in_ready` is high only when the input stage is empty and no write is in progress.
- R3: A rising `shift_in` while `in_ready` is high captures `data_in` into the input stage, and `in_ready` is low three clocks after the strobe rises.
- R4: While `shift_in` stays high, the captured word stays in the input stage: it does not reach the output, and later changes of `data_in` do not alter it.
- R5: After `shift_in` falls, the word moves downstream and `in_ready` returns high, unless all 64 cells are full; in that case it stays low.
- R6: No word is lost or duplicated inside the chain. In an empty buffer a released word reaches the output stage within 2×64+8 clocks.
- R7: `out_ready` is high only when the output stage holds a valid word, and `data_out` shows that word.
- R8: A rising `shift_out` while `out_ready` is high drives `out_ready` low, and `data_out` stays stable while `shift_out` stays high.
- R9: After `shift_out` falls, the next upstream word, if any, enters the output stage and `out_ready` rises again.
- R10: When the buffer is empty, `out_ready` stays low and `data_out` keeps its last value.
- R11: While `rst_n` is low, every cell empties, `in_ready` is high, `out_ready` is low and `data_out` is 0.
- R12: A rising `shift_in` while `in_ready` is low stores nothing, and a rising `shift_out` while `out_ready` is low removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| data_in | input | 4 | Word to be written |
| shift_in | input | 1 | Write strobe; rise captures, fall releases |
| in_ready | output | 1 | Input stage empty and able to accept a word |
| shift_out | input | 1 | Read strobe; rise claims, fall removes |
| out_ready | output | 1 | Valid word present at `data_out` |
| data_out | output | 4 | Word in the output stage |

## Verification
The bench fills all 64 cells and confirms that `in_ready` stays low. A design with an off-by-one in the chain would reopen early or hold one word fewer. It then drains the buffer and compares the words in order, which exposes a ripple step that duplicates or drops a word at a bubble. It holds each strobe high for a long time: a design that let the input word advance before release would raise `out_ready` too soon, and one that let the output stage refill during a read would change `data_out` under the reader. Strobes raised while the matching ready line is low must neither add nor remove a word. A design that ignored that condition would return an extra word or lose one.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

    typedef enum logic [1:0] {
        WR_OPEN  = 2'd0,
        WR_HOLD  = 2'd1,
        WR_DRAIN = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_READY = 2'd1,
        RD_HOLD  = 2'd2
    } rd_state_t;

endpackage

// File: rtl/rf_edge.sv
module rf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= strobe;
            s2_q <= s1_q;
        end
    end

    assign rise = s1_q & ~s2_q;
    assign fall = ~s1_q & s2_q;
endmodule

// File: rtl/rf_chain.sv
module rf_chain #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             hold_head,
    input  logic             pop,
    output logic [DEPTH-1:0] occ,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = DEPTH - 1;

    logic [WIDTH-1:0] word [DEPTH];
    logic [DEPTH-2:0] move;

    // A cell hands its word on when the next cell is empty; the head cell waits for release.
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_move
        if (i == 0) begin : g_head
            assign move[i] = occ[i] & ~occ[i+1] & ~hold_head;
        end else begin : g_body
            assign move[i] = occ[i] & ~occ[i+1];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic             v_q;
        logic [WIDTH-1:0] d_q;

        if (i == 0) begin : g_in
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else if (load) begin
                    v_q <= 1'b1;
                    d_q <= din;
                end else if (move[i]) begin
                    v_q <= 1'b0;
                end
            end
        end else if (i == LAST) begin : g_out
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else if (move[i-1]) begin
                    v_q <= 1'b1;
                    d_q <= word[i-1];
                end else if (pop) begin
                    v_q <= 1'b0;
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else if (move[i-1]) begin
                    v_q <= 1'b1;
                    d_q <= word[i-1];
                end else if (move[i]) begin
                    v_q <= 1'b0;
                end
            end
        end

        assign occ[i]  = v_q;
        assign word[i] = d_q;
    end

    assign dout = word[LAST];
endmodule

// File: rtl/rf_wr_ctl.sv
module rf_wr_ctl
    import ripple_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic head_occ,
    output logic load,
    output logic hold_head,
    output logic ready
);
    wr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        hold_head = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            WR_OPEN: begin
                ready = 1'b1;
                if (rise) begin
                    load    = 1'b1;
                    state_d = WR_HOLD;
                end
            end
            WR_HOLD: begin
                hold_head = 1'b1;
                if (fall) state_d = WR_DRAIN;
            end
            WR_DRAIN: begin
                if (!head_occ) state_d = WR_OPEN;
            end
            default: state_d = WR_OPEN;
        endcase
    end
endmodule

// File: rtl/rf_rd_ctl.sv
module rf_rd_ctl
    import ripple_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic tail_occ,
    output logic pop,
    output logic hold,
    output logic ready
);
    rd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        hold    = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            RD_EMPTY: begin
                if (tail_occ) state_d = RD_READY;
            end
            RD_READY: begin
                ready = 1'b1;
                if (rise) state_d = RD_HOLD;
            end
            RD_HOLD: begin
                hold = 1'b1;
                if (fall) begin
                    pop     = 1'b1;
                    state_d = RD_EMPTY;
                end
            end
            default: state_d = RD_EMPTY;
        endcase
    end
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             shift_in,
    output logic             in_ready,
    input  logic             shift_out,
    output logic             out_ready,
    output logic [WIDTH-1:0] data_out
);
    logic             si_rise, si_fall, so_rise, so_fall;
    logic             load, hold_head, pop, rd_hold;
    logic [DEPTH-1:0] occ;

    rf_edge u_si_edge (
        .clk(clk), .rst_n(rst_n), .strobe(shift_in), .rise(si_rise), .fall(si_fall)
    );

    rf_edge u_so_edge (
        .clk(clk), .rst_n(rst_n), .strobe(shift_out), .rise(so_rise), .fall(so_fall)
    );

    rf_wr_ctl u_wr (
        .clk(clk), .rst_n(rst_n), .rise(si_rise), .fall(si_fall),
        .head_occ(occ[0]), .load(load), .hold_head(hold_head), .ready(in_ready)
    );

    rf_rd_ctl u_rd (
        .clk(clk), .rst_n(rst_n), .rise(so_rise), .fall(so_fall),
        .tail_occ(occ[DEPTH-1]), .pop(pop), .hold(rd_hold), .ready(out_ready)
    );

    rf_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
        .clk(clk), .rst_n(rst_n), .load(load), .din(data_in), .hold_head(hold_head),
        .pop(pop), .occ(occ), .dout(data_out)
    );
endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_ready,
    input logic [WIDTH-1:0] data_out,
    input logic [DEPTH-1:0] occ,
    input logic             hold_head,
    input logic             rd_hold,
    input logic             pop
);
    p_ready_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !occ[0]);

    p_head_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_head |-> occ[0]);

    p_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pop) |-> $countones(occ) >= $countones($past(occ)));

    p_ready_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> occ[DEPTH-1]);

    p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && $past(rd_hold)) |-> $stable(data_out));

    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !out_ready);
endmodule

bind ripple_fifo ripple_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_ready(out_ready),
    .data_out(data_out), .occ(occ), .hold_head(hold_head), .rd_hold(rd_hold), .pop(pop)
);

// File: tb/ripple_fifo_tb.sv
module ripple_fifo_tb;
    localparam int W = 4;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         shift_in = 1'b0;
    logic         shift_out = 1'b0;
    logic         in_ready, out_ready;
    logic [W-1:0] data_out;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    ripple_fifo #(.WIDTH(W), .DEPTH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .shift_in(shift_in),
        .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
        .data_out(data_out)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_in_ready(input string req);
        int k = 0;
        while (!in_ready && k < 400) begin tick(); k++; end
        check(in_ready == 1'b1, req, in_ready, 1);
    endtask

    task automatic wait_out_ready(input string req, output int cycles);
        cycles = 0;
        while (!out_ready && cycles < 400) begin tick(); cycles++; end
        check(out_ready == 1'b1, req, out_ready, 1);
    endtask

    task automatic push(input logic [W-1:0] w);
        wait_in_ready("R5 in_ready before write");
        data_in  = w;
        shift_in = 1'b1;
        tick(3);
        shift_in = 1'b0;
        tick(2);
    endtask

    task automatic pop_word(output logic [W-1:0] w);
        int c;
        wait_out_ready("R9 out_ready before read", c);
        w = data_out;
        shift_out = 1'b1;
        tick(3);
        shift_out = 1'b0;
        tick(2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        shift_in = 1'b0;
        shift_out = 1'b0;
        tick(3);
        check(in_ready == 1'b1, "R11 in_ready in reset", in_ready, 1);
        check(out_ready == 1'b0, "R11 out_ready in reset", out_ready, 0);
        check(data_out == '0, "R11 data_out in reset", data_out, 0);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_single();
        int c;
        push(4'h5);
        wait_out_ready("R6 word reaches output", c);
        check(c <= 2 * N + 8, "R6 ripple latency", c, 2 * N + 8);
        check(data_out == 4'h5, "R7 data_out shows word", data_out, 5);
    endtask

    task automatic t_read_hold();
        logic [W-1:0] held;
        held = data_out;
        shift_out = 1'b1;
        tick(3);
        check(out_ready == 1'b0, "R8 out_ready low during read", out_ready, 0);
        tick(10);
        check(data_out == held, "R8 data_out stable during read", data_out, held);
        shift_out = 1'b0;
        tick(150);
        check(out_ready == 1'b0, "R10 out_ready low when empty", out_ready, 0);
        check(data_out == 4'h5, "R10 data_out keeps last word", data_out, 5);
    endtask

    task automatic t_write_hold();
        int c;
        logic [W-1:0] w;
        data_in = 4'h9;
        shift_in = 1'b1;
        tick(3);
        check(in_ready == 1'b0, "R3 in_ready low after capture", in_ready, 0);
        data_in = 4'h2;
        tick(150);
        check(out_ready == 1'b0, "R4 word held at input", out_ready, 0);
        shift_in = 1'b0;
        wait_out_ready("R4 word released", c);
        check(data_out == 4'h9, "R4 captured value kept", data_out, 9);
        check(in_ready == 1'b1, "R5 in_ready back high", in_ready, 1);
        pop_word(w);
    endtask

    task automatic t_ignore_read();
        logic [W-1:0] w;
        shift_out = 1'b1;
        tick(4);
        shift_out = 1'b0;
        tick(4);
        push(4'h3);
        pop_word(w);
        check(w == 4'h3, "R12 read strobe while empty removed nothing", w, 3);
    endtask

    task automatic t_fill_drain();
        logic [W-1:0] w;
        for (int i = 0; i < N; i++) push(W'((i * 7 + 1) % 16));
        tick(200);
        check(in_ready == 1'b0, "R5 in_ready low when full", in_ready, 0);
        data_in = 4'hF;
        shift_in = 1'b1;
        tick(4);
        shift_in = 1'b0;
        tick(4);
        for (int i = 0; i < N; i++) begin
            pop_word(w);
            check(w == W'((i * 7 + 1) % 16), "R1 order after fill", w, (i * 7 + 1) % 16);
        end
        tick(200);
        check(out_ready == 1'b0, "R12 no extra word after full write", out_ready, 0);
        check(data_out == W'(((N - 1) * 7 + 1) % 16), "R10 last word kept",
              data_out, ((N - 1) * 7 + 1) % 16);
        check(in_ready == 1'b1, "R2 in_ready high when drained", in_ready, 1);
    endtask

    task automatic t_reset_mid();
        push(4'hA);
        push(4'hB);
        do_reset();
        tick(150);
        check(out_ready == 1'b0, "R11 reset discarded words", out_ready, 0);
    endtask

    initial begin
        do_reset();
        t_single();
        t_read_hold();
        t_write_hold();
        t_ignore_read();
        t_fill_drain();
        t_reset_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule